// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer that connects two unrelated clock domains. Words of DW bits (9 by default) are written on the write clock and read on the read clock. Storage is a dual-port array of 2^AW words. Both enables are active low. Reset is active low and synchronous: each domain samples it on its own clock.

The block drives four active-low status outputs. Two of them, empty and full, mark the hard boundaries. The other two, almost-empty and almost-full, assert at distances n and m from those boundaries. The offsets n and m arrive as static inputs from a neighbouring register block, and a change takes effect on the next edge of the clock that owns the flag.

A retransmit request rewinds the read pointer to physical location zero, so the words already stored can be replayed. Pointers carry one wrap bit beyond the address. Each pointer crosses to the other domain as Gray code through a synchroniser chain. As a result, empty and full can deassert a few cycles late, but they never assert late.

A small finite-state machine on the read side turns the synchronised retransmit level into a single rewind. The machine has two states:
- `RW_IDLE` goes to `RW_HELD` when the synchronised request is seen high. The rewind happens on that transition, and no read is taken in that cycle.
- `RW_HELD` goes back to `RW_IDLE` once the request is seen low again.

Top module: `xclk_flag_fifo`

## Requirements
- R1: A word is stored on a rising wr_clk edge only when wr_en_n is low and full_n is high. A write attempted while full_n is low is dropped and the write pointer does not move.
- R2: On a rising rd_clk edge where rd_en_n is low and empty_n is high, the oldest unread word appears on rd_data. Words come out in the order they were written, and rd_data changes on no other edge.
- R3: While empty_n is low, read attempts leave rd_data holding the last word delivered.
- R4: empty_n is updated only on rd_clk. Once both sides have been idle for a few cycles, empty_n is low exactly when 0 words are stored.
- R5: full_n is updated only on wr_clk. Once both sides have settled, full_n is low exactly when 2^AW words are stored.
- R6: aempty_n is updated on rd_clk. It is low when the stored count is less than or equal to ae_ofs (an unsigned AW-bit offset n) and high when the count is n+1 or more. It is therefore low whenever empty_n is low.
- R7: afull_n is updated on wr_clk. It is low when the stored count is 2^AW − af_ofs or more (af_ofs is an unsigned AW-bit offset m), and high when more than m locations are free. It is therefore low whenever full_n is low.
- R8: While rst_n is low, every edge of a domain sets that domain's outputs: rd_data = 0, empty_n = 0 and aempty_n = 0 on rd_clk; full_n = 1 and afull_n = 1 on wr_clk.
- R9: The retransmit level rtx must be held high for at least three rd_clk cycles with both enables idle. Its first synchronised high level sets the read pointer to location 0, and the flags are recomputed from that pointer. Later reads then deliver every word written since reset in order, including words written after the rewind. This holds provided no more than 2^AW words have been written and at least one has been read.
- R10: After a write into an empty buffer, empty_n rises within six rd_clk cycles. The read taken on the first rd_clk edge after it rises returns the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously by each domain |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | DW | Word to store |
| rd_en_n | input | 1 | Active-low read enable |
| rd_data | output | DW | Registered read word |
| rtx | input | 1 | Retransmit request (level, synchronised into the read domain) |
| ae_ofs | input | AW | Almost-empty offset n |
| af_ofs | input | AW | Almost-full offset m |
| empty_n | output | 1 | Low when empty (read domain) |
| aempty_n | output | 1 | Low when almost empty (read domain) |
| full_n | output | 1 | Low when full (write domain) |
| afull_n | output | 1 | Low when almost full (write domain) |

## Verification
The assertions check on every cycle:
- that the write Gray pointer moves by at most one bit, and only on an accepted write;
- that rd_data moves only on an accepted read, and never while empty_n is low;
- that each almost flag is asserted whenever its boundary flag is asserted;
- the reset values of both domains.

Only the bench scenarios can show that the settled flags match the stored count at every fill level and every offset value, that data keeps its order through full-buffer back-pressure, and that a rewind replays the stored words followed by words written afterwards.

// File: rtl/xcf_pkg.sv
package xcf_pkg;

    // Read-side rewind controller states
    typedef enum logic [0:0] {
        RW_IDLE = 1'b0,   // no request outstanding; reads proceed
        RW_HELD = 1'b1    // rewind done; waiting for the request to drop
    } rewind_st_t;

    localparam int SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/xcf_sync.sv
module xcf_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/xcf_g2b.sv
module xcf_g2b #(
    parameter int W = 5
) (
    input  logic [W-1:0] g,
    output logic [W-1:0] b
);
    assign b[W-1] = g[W-1];
    for (genvar i = 0; i < W-1; i++) begin : g_bit
        assign b[i] = b[i+1] ^ g[i];
    end
endmodule

// File: rtl/xcf_store.sv
module xcf_store #(
    parameter int DW = 9,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] q
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk) begin
        if (!rst_n)  q <= '0;
        else if (re) q <= mem[raddr];
    end
endmodule

// File: rtl/xcf_wr_ctl.sv
module xcf_wr_ctl #(
    parameter int AW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic [AW:0]   rgray_a,
    input  logic [AW-1:0] af_ofs,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          full_n,
    output logic          afull_n
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] wbin, wbin_nx, rgray_s, rbin_s, used_nx, af_lim;

    xcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
        .clk(clk), .rst_n(rst_n), .d(rgray_a), .q(rgray_s)
    );

    xcf_g2b #(.W(PW)) u_rconv (.g(rgray_s), .b(rbin_s));

    always_comb begin
        we      = !wr_en_n && full_n;
        wbin_nx = wbin + PW'(we);
        used_nx = wbin_nx - rbin_s;
        af_lim  = PW'(DEPTH) - {1'b0, af_ofs};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin    <= '0;
            wgray   <= '0;
            full_n  <= 1'b1;
            afull_n <= 1'b1;
        end else begin
            wbin    <= wbin_nx;
            wgray   <= wbin_nx ^ (wbin_nx >> 1);
            full_n  <= (used_nx != PW'(DEPTH));
            afull_n <= (used_nx < af_lim);
        end
    end

    assign waddr = wbin[AW-1:0];
endmodule

// File: rtl/xcf_rd_ctl.sv
module xcf_rd_ctl
    import xcf_pkg::*;
#(
    parameter int AW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en_n,
    input  logic          rtx_s,
    input  logic [AW:0]   wgray_a,
    input  logic [AW-1:0] ae_ofs,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          empty_n,
    output logic          aempty_n
);
    localparam int PW = AW + 1;

    rewind_st_t    state, state_nx;
    logic [PW-1:0] rbin, rbin_nx, wgray_s, wbin_s, used_nx;

    xcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
        .clk(clk), .rst_n(rst_n), .d(wgray_a), .q(wgray_s)
    );

    xcf_g2b #(.W(PW)) u_wconv (.g(wgray_s), .b(wbin_s));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RW_IDLE;
        else        state <= state_nx;
    end

    // next state and per-cycle outputs
    always_comb begin
        state_nx = state;
        re       = 1'b0;
        rbin_nx  = rbin;
        unique case (state)
            RW_IDLE: begin
                if (rtx_s) begin
                    state_nx = RW_HELD;
                    rbin_nx  = '0;
                end else if (!rd_en_n && empty_n) begin
                    re      = 1'b1;
                    rbin_nx = rbin + PW'(1);
                end
            end
            RW_HELD: begin
                if (!rtx_s) state_nx = RW_IDLE;
                if (!rd_en_n && empty_n) begin
                    re      = 1'b1;
                    rbin_nx = rbin + PW'(1);
                end
            end
        endcase
        used_nx = wbin_s - rbin_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            empty_n  <= 1'b0;
            aempty_n <= 1'b0;
        end else begin
            rbin     <= rbin_nx;
            rgray    <= rbin_nx ^ (rbin_nx >> 1);
            empty_n  <= (used_nx != '0);
            aempty_n <= (used_nx > {1'b0, ae_ofs});
        end
    end

    assign raddr = rbin[AW-1:0];
endmodule

// File: rtl/xclk_flag_fifo.sv
module xclk_flag_fifo
    import xcf_pkg::*;
#(
    parameter int DW          = 9,
    parameter int AW          = 4,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en_n,
    output logic [DW-1:0] rd_data,
    input  logic          rtx,
    input  logic [AW-1:0] ae_ofs,
    input  logic [AW-1:0] af_ofs,
    output logic          empty_n,
    output logic          aempty_n,
    output logic          full_n,
    output logic          afull_n
);
    localparam int PW = AW + 1;

    logic          we, re, rtx_s;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray_q, rgray_q;

    xcf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rtx_sync (
        .clk(rd_clk), .rst_n(rst_n), .d(rtx), .q(rtx_s)
    );

    xcf_wr_ctl #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .rgray_a(rgray_q),
        .af_ofs(af_ofs), .we(we), .waddr(waddr), .wgray(wgray_q),
        .full_n(full_n), .afull_n(afull_n)
    );

    xcf_rd_ctl #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .rtx_s(rtx_s),
        .wgray_a(wgray_q), .ae_ofs(ae_ofs), .re(re), .raddr(raddr),
        .rgray(rgray_q), .empty_n(empty_n), .aempty_n(aempty_n)
    );

    xcf_store #(.DW(DW), .AW(AW)) u_mem (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .rst_n(rst_n), .re(re), .raddr(raddr), .q(rd_data)
    );
endmodule

// File: rtl/xclk_flag_fifo_chk.sv
module xclk_flag_fifo_chk #(
    parameter int DW = 9,
    parameter int PW = 5
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en_n,
    input logic          rd_en_n,
    input logic          full_n,
    input logic          afull_n,
    input logic          empty_n,
    input logic          aempty_n,
    input logic [DW-1:0] rd_data,
    input logic [PW-1:0] wgray
);
    // R1: a refused or absent write leaves the write pointer where it was
    a_r1_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en_n || !full_n) |=> $stable(wgray));

    // R1: the Gray write pointer never moves by more than one bit per edge
    a_r1_gray_one_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $onehot0(wgray ^ $past(wgray)));

    // R2: output word moves only on an accepted read
    a_r2_hold_idle: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_en_n |=> $stable(rd_data));

    // R3: reads into an empty buffer keep the last word
    a_r3_hold_empty: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |=> $stable(rd_data));

    // R6: almost-empty is asserted whenever empty is
    a_r6_ae_covers_empty: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    // R7: almost-full is asserted whenever full is
    a_r7_af_covers_full: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !afull_n);

    // R8: read-domain reset values
    a_r8_rd_reset: assert property (@(posedge rd_clk)
        !rst_n |=> (rd_data == '0 && !empty_n && !aempty_n));

    // R8: write-domain reset values
    a_r8_wr_reset: assert property (@(posedge wr_clk)
        !rst_n |=> (full_n && afull_n));
endmodule

bind xclk_flag_fifo xclk_flag_fifo_chk #(.DW(DW), .PW(PW)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
    .rd_en_n(rd_en_n), .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n),
    .aempty_n(aempty_n), .rd_data(rd_data), .wgray(wgray_q)
);

// File: tb/xclk_flag_fifo_test.sv
`timescale 1ns/100ps
module xclk_flag_fifo_test;
    localparam int DW    = 9;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic          wr_en_n = 1'b1, rd_en_n = 1'b1, rtx = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] ae_ofs = AW'(3), af_ofs = AW'(2);
    logic          empty_n, aempty_n, full_n, afull_n;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [DW-1:0] q[$];

    always #2.5 wr_clk = ~wr_clk;   // 200 MHz
    always #3.5 rd_clk = ~rd_clk;

    xclk_flag_fifo #(.DW(DW), .AW(AW)) uut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
        .wr_data(wr_data), .rd_en_n(rd_en_n), .rd_data(rd_data), .rtx(rtx),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .empty_n(empty_n), .aempty_n(aempty_n),
        .full_n(full_n), .afull_n(afull_n)
    );

    function automatic logic [DW-1:0] pat(int k);
        return DW'((k * 37 + 5) % 512);
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_flags(string ctx, int cnt);
        check({ctx, " R4 empty_n"},  DW'(empty_n),  DW'(cnt != 0));
        check({ctx, " R5 full_n"},   DW'(full_n),   DW'(cnt != DEPTH));
        check({ctx, " R6 aempty_n"}, DW'(aempty_n), DW'(cnt > int'(ae_ofs)));
        check({ctx, " R7 afull_n"},  DW'(afull_n),  DW'(cnt < DEPTH - int'(af_ofs)));
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
    endtask

    task automatic do_reset();
        @(negedge wr_clk) rst_n = 1'b0;
        repeat (10) @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (3) @(negedge rd_clk);
    endtask

    task automatic push(int k);
        @(negedge wr_clk);
        wr_en_n = 1'b0;
        wr_data = pat(k);
        @(negedge wr_clk);
        wr_en_n = 1'b1;
    endtask

    task automatic pop();
        @(negedge rd_clk) rd_en_n = 1'b0;
        @(negedge rd_clk) rd_en_n = 1'b1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #900000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int cnt;
        int waited;
        // R8: reset state
        repeat (10) @(negedge wr_clk);
        rst_n = 1'b1;
        repeat (3) @(negedge rd_clk);
        check("R8 rd_data", rd_data, '0);
        check("R8 empty_n", DW'(empty_n), '0);
        check("R8 aempty_n", DW'(aempty_n), '0);
        check("R8 full_n", DW'(full_n), 1);
        check("R8 afull_n", DW'(afull_n), 1);

        // fill sweep: flags at every level
        cnt = 0;
        for (int k = 0; k < DEPTH; k++) begin
            push(k);
            cnt++;
            settle();
            check_flags("fill", cnt);
        end

        // R1: write while full is dropped (flags unchanged, drain order intact)
        push(99);
        settle();
        check_flags("R1 overflow", DEPTH);

        // drain sweep with an offset sweep at a middle level
        for (int k = 0; k < DEPTH; k++) begin
            pop();
            check("R2 drain order", rd_data, pat(k));
            cnt--;
            settle();
            check_flags("drain", cnt);
            if (cnt == 9) begin
                for (int v = 0; v < DEPTH; v++) begin
                    @(negedge wr_clk);
                    ae_ofs = AW'(v);
                    af_ofs = AW'(v);
                    settle();
                    check("R6 offset sweep", DW'(aempty_n), DW'(9 > v));
                    check("R7 offset sweep", DW'(afull_n), DW'(9 < DEPTH - v));
                end
                @(negedge wr_clk);
                ae_ofs = AW'(3);
                af_ofs = AW'(2);
                settle();
            end
        end

        // R3: reads while empty keep the last word
        for (int k = 0; k < 3; k++) begin
            pop();
            check("R3 empty read", rd_data, pat(DEPTH - 1));
        end
        settle();
        check_flags("R3 after empty reads", 0);

        // R10: first word after empty
        push(200);
        waited = 0;
        while (!empty_n && waited < 12) begin
            @(negedge rd_clk);
            waited++;
        end
        check("R10 empty_n rise time", DW'(waited <= 6), 1);
        pop();
        check("R10 first word", rd_data, pat(200));

        // R9: retransmit
        do_reset();
        for (int k = 0; k < 6; k++) push(k);
        settle();
        for (int k = 0; k < 3; k++) begin
            pop();
            check("R9 before rewind", rd_data, pat(k));
        end
        settle();
        check_flags("R9 before rewind", 3);
        @(negedge rd_clk) rtx = 1'b1;
        repeat (3) @(negedge rd_clk);
        rtx = 1'b0;
        settle();
        check_flags("R9 rewound", 6);
        for (int k = 0; k < 6; k++) begin
            pop();
            check("R9 replay", rd_data, pat(k));
        end
        push(6);
        push(7);
        settle();
        for (int k = 6; k < 8; k++) begin
            pop();
            check("R9 after rewind", rd_data, pat(k));
        end
        settle();
        check_flags("R9 drained", 0);

        // R1/R2: streaming with back-pressure through full
        do_reset();
        fork
            begin : writer
                int i = 0;
                int c = 0;
                while (i < 60) begin
                    @(negedge wr_clk);
                    c++;
                    if (c % 7 == 0) begin
                        wr_en_n = 1'b1;
                    end else if (full_n) begin
                        wr_en_n = 1'b0;
                        wr_data = pat(300 + i);
                        q.push_back(pat(300 + i));
                        i++;
                    end else begin
                        wr_en_n = 1'b0;      // refused: must be dropped (R1)
                        wr_data = '1;
                    end
                end
                @(negedge wr_clk) wr_en_n = 1'b1;
            end
            begin : reader
                int got = 0;
                int c = 0;
                bit pend = 0;
                while (got < 60) begin
                    @(negedge rd_clk);
                    c++;
                    if (pend) begin
                        if (q.size() == 0) begin
                            check("R2 stream underflow", rd_data, '1);
                            checks++;
                            fails++;
                            $display("FAIL R2 stream extra word actual=%h expected=none", rd_data);
                        end else begin
                            check("R2 stream order", rd_data, q.pop_front());
                        end
                        got++;
                    end
                    if (got < 60 && c > 30 && c % 5 != 0 && empty_n) begin
                        rd_en_n = 1'b0;
                        pend = 1'b1;
                    end else begin
                        rd_en_n = 1'b1;
                        pend = 1'b0;
                    end
                end
                rd_en_n = 1'b1;
            end
        join
        settle();
        check_flags("R2 stream end", 0);

        done = 1;
        summary();
        $finish;
    end
endmodule